// File: doc/BRIEF.md
# Legacy Shadow Segment Router

This block decides, for every processor memory access that lands in the legacy upper region from 0C0000h to 0FFFFFh, whether the access is served by main DRAM or sent on to the ROM/bus side. The region is split into sixteen 16 KB segments. Each segment holds two attribute bits: one sends reads to DRAM, the other sends writes to DRAM. Reads and writes are routed separately, so one segment can serve reads from ROM while it accepts writes into DRAM.

That split routing supports the usual shadowing flow. Firmware first lets writes reach DRAM while reads still come from ROM. It reads each ROM location and writes the value back to the same address, which copies the ROM into DRAM. It then switches the segment so reads come from DRAM, and the code runs from the faster memory. A write to a segment that reads from DRAM but does not write to it is treated as write-protected: the DRAM write is dropped, the access goes to the bus side, and a drop strobe marks it.

The attributes are written through a simple configuration port, one segment per write. Each routing decision is registered and appears one cycle after the access is presented.

Top module: `shadow_router`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `dram_sel`, `fwd_sel` and `wr_drop` are low. Reset clears every segment's attributes to 0 (read and write both forwarded).
- R2: An access presented with `acc_valid`=1 in cycle t raises exactly one of `dram_sel`/`fwd_sel` in cycle t+1, if its address is inside the window. With no valid access, or with an address outside 0C0000h..0FFFFFh, both strobes are low in cycle t+1.
- R3: A read (`acc_write`=0) goes to DRAM when the segment's read attribute (`cfg_rd_dram`) is 1, and is forwarded otherwise.
- R4: A write (`acc_write`=1) goes to DRAM when the segment's write attribute (`cfg_wr_dram`) is 1, and is forwarded otherwise.
- R5: With both attributes 0, every access to the segment is forwarded. With both set to 1, every access goes to DRAM.
- R6: A write to a segment whose read attribute is 1 and whose write attribute is 0 is forwarded, and `wr_drop` is high together with `fwd_sel`. `wr_drop` is never high in any other case.
- R7: The segment index is address bits [17:14]. The window matches only when bits [31:18] equal 3, so addresses at or above 100000h that alias these low bits do not match. Writing one segment's attributes leaves every other segment unchanged.
- R8: A configuration write (`cfg_we`=1) in cycle t governs accesses from cycle t+1 on. An access presented in cycle t itself is routed with the earlier attributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Attribute write strobe |
| cfg_seg | input | 4 | Segment index being configured |
| cfg_rd_dram | input | 1 | New read attribute (1 = reads to DRAM) |
| cfg_wr_dram | input | 1 | New write attribute (1 = writes to DRAM) |
| acc_valid | input | 1 | Processor access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Processor byte address |
| dram_sel | output | 1 | Access is routed to main DRAM (one cycle after access) |
| fwd_sel | output | 1 | Access is forwarded to the ROM/bus side |
| wr_drop | output | 1 | Forwarded write whose DRAM write was suppressed by protection |

## Verification
A corrupted attribute bit never shows up by itself. It becomes visible only when an access of the matching direction hits that exact segment, and then the wrong strobe rises one cycle later. For that reason the vectors touch both directions in each configured segment, and they include a segment that was left unconfigured, to catch writes leaking across segments. A timing fault in the attribute update is visible only when an access arrives in the same cycle as the configuration write. That case is driven on purpose, and the result is checked in the cycle that follows.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

    // Routing attributes held for one segment
    typedef struct packed {
        logic rd_dram;
        logic wr_dram;
    } seg_attr_t;

    // Registered routing decision for one access
    typedef struct packed {
        logic dram;
        logic fwd;
        logic drop;
    } route_t;

endpackage

// File: rtl/shadow_attr_regs.sv
module shadow_attr_regs
    import shadow_pkg::*;
#(
    parameter int SEG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEG_W-1:0] cfg_seg,
    input  seg_attr_t        cfg_attr,
    input  logic [SEG_W-1:0] look_seg,
    output seg_attr_t        look_attr
);
    localparam int NUM_SEG = 1 << SEG_W;

    seg_attr_t attr_d [NUM_SEG];
    seg_attr_t attr_q [NUM_SEG];

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        localparam logic [SEG_W-1:0] IDX = SEG_W'(i);

        always_comb begin
            attr_d[i] = attr_q[i];
            if (cfg_we && (cfg_seg == IDX)) begin
                attr_d[i] = cfg_attr;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                attr_q[i] <= '0;
            end else begin
                attr_q[i] <= attr_d[i];
            end
        end
    end

    // Lookup uses the stored value, so a same-cycle write is not yet visible
    assign look_attr = attr_q[look_seg];

endmodule

// File: rtl/shadow_decode.sv
module shadow_decode #(
    parameter int                ADDR_W    = 32,
    parameter int                SEG_SHIFT = 14,
    parameter int                SEG_W     = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h000C_0000
) (
    input  logic [ADDR_W-1:SEG_SHIFT] addr_hi,
    output logic                      in_win,
    output logic [SEG_W-1:0]          seg
);
    localparam int TAG_LSB = SEG_SHIFT + SEG_W;

    always_comb begin
        in_win = (addr_hi[ADDR_W-1:TAG_LSB] == WIN_BASE[ADDR_W-1:TAG_LSB]);
        seg    = addr_hi[TAG_LSB-1:SEG_SHIFT];
    end

endmodule

// File: rtl/shadow_route_sel.sv
module shadow_route_sel
    import shadow_pkg::*;
(
    input  logic      valid,
    input  logic      in_win,
    input  logic      write,
    input  seg_attr_t attr,
    output route_t    route
);
    logic to_dram;

    always_comb begin
        to_dram = write ? attr.wr_dram : attr.rd_dram;
        route   = '0;
        if (valid && in_win) begin
            route.dram = to_dram;
            route.fwd  = !to_dram;
            route.drop = write && attr.rd_dram && !attr.wr_dram;
        end
    end

endmodule

// File: rtl/shadow_router.sv
module shadow_router
    import shadow_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                SEG_SHIFT = 14,
    parameter int                SEG_W     = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h000C_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEG_W-1:0]  cfg_seg,
    input  logic              cfg_rd_dram,
    input  logic              cfg_wr_dram,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              dram_sel,
    output logic              fwd_sel,
    output logic              wr_drop
);
    typedef struct packed {
        route_t route;
    } state_t;

    state_t           state_d;
    state_t           state_q;
    logic             in_win;
    logic [SEG_W-1:0] hit_seg;
    seg_attr_t        cfg_attr;
    seg_attr_t        cur_attr;
    route_t           next_route;
    logic             unused_lo;

    assign unused_lo = ^acc_addr[SEG_SHIFT-1:0];

    always_comb begin
        cfg_attr.rd_dram = cfg_rd_dram;
        cfg_attr.wr_dram = cfg_wr_dram;
    end

    shadow_decode #(
        .ADDR_W   (ADDR_W),
        .SEG_SHIFT(SEG_SHIFT),
        .SEG_W    (SEG_W),
        .WIN_BASE (WIN_BASE)
    ) u_decode (
        .addr_hi(acc_addr[ADDR_W-1:SEG_SHIFT]),
        .in_win (in_win),
        .seg    (hit_seg)
    );

    shadow_attr_regs #(
        .SEG_W(SEG_W)
    ) u_attr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_seg  (cfg_seg),
        .cfg_attr (cfg_attr),
        .look_seg (hit_seg),
        .look_attr(cur_attr)
    );

    shadow_route_sel u_sel (
        .valid (acc_valid),
        .in_win(in_win),
        .write (acc_write),
        .attr  (cur_attr),
        .route (next_route)
    );

    always_comb begin
        state_d       = state_q;
        state_d.route = next_route;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign dram_sel = state_q.route.dram;
    assign fwd_sel  = state_q.route.fwd;
    assign wr_drop  = state_q.route.drop;

endmodule

// File: rtl/shadow_router_chk.sv
module shadow_router_chk (
    input logic clk,
    input logic rst_n,
    input logic acc_valid,
    input logic acc_write,
    input logic in_win,
    input logic seg_rd_dram,
    input logic seg_wr_dram,
    input logic dram_sel,
    input logic fwd_sel,
    input logic wr_drop
);
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !(dram_sel && fwd_sel)); // R2

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && in_win) |=> !dram_sel && !fwd_sel); // R2

    AST_READ_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && in_win && !acc_write && !seg_rd_dram |=> fwd_sel); // R3

    AST_WRITE_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && in_win && acc_write && seg_wr_dram |=> dram_sel); // R4

    AST_FULL_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && in_win && seg_rd_dram && seg_wr_dram |=> dram_sel && !wr_drop); // R5

    AST_DROP_ON_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drop |-> fwd_sel); // R6

    AST_PROTECTED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && in_win && acc_write && seg_rd_dram && !seg_wr_dram |=> wr_drop); // R6

endmodule

bind shadow_router shadow_router_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .in_win     (in_win),
    .seg_rd_dram(cur_attr.rd_dram),
    .seg_wr_dram(cur_attr.wr_dram),
    .dram_sel   (dram_sel),
    .fwd_sel    (fwd_sel),
    .wr_drop    (wr_drop)
);

// File: tb/shadow_router_bench.sv
`timescale 1ns/1ps
module shadow_router_bench;
    // Vector: cfg(1) seg(4) rd(1) wr(1) addr(32) write(1) exp{dram,fwd,drop}(3)
    localparam int VW = 43;
    localparam int NV = 16;
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 4'd0,  1'b0, 1'b0, 32'h000C_0000, 1'b0, 3'b010}, // R5 reset attrs: read fwd
        {1'b0, 4'd0,  1'b0, 1'b0, 32'h000C_0000, 1'b1, 3'b010}, // R5 write fwd
        {1'b1, 4'd0,  1'b0, 1'b1, 32'h0000_0000, 1'b0, 3'b000}, // copy phase config
        {1'b0, 4'd0,  1'b0, 1'b0, 32'h000C_0000, 1'b0, 3'b010}, // R3 read from ROM
        {1'b0, 4'd0,  1'b0, 1'b0, 32'h000C_0004, 1'b1, 3'b100}, // R4 write into DRAM
        {1'b1, 4'd0,  1'b1, 1'b0, 32'h0000_0000, 1'b0, 3'b000}, // shadowed, protected
        {1'b0, 4'd0,  1'b0, 1'b0, 32'h000C_3FFF, 1'b0, 3'b100}, // R3 read from DRAM
        {1'b0, 4'd0,  1'b0, 1'b0, 32'h000C_0010, 1'b1, 3'b011}, // R6 dropped write
        {1'b1, 4'd15, 1'b1, 1'b1, 32'h0000_0000, 1'b0, 3'b000}, // top segment full DRAM
        {1'b0, 4'd0,  1'b0, 1'b0, 32'h000F_FFFF, 1'b0, 3'b100}, // R5 read DRAM
        {1'b0, 4'd0,  1'b0, 1'b0, 32'h000F_C000, 1'b1, 3'b100}, // R5 write DRAM
        {1'b0, 4'd0,  1'b0, 1'b0, 32'h000F_8000, 1'b0, 3'b010}, // R7 seg14 untouched
        {1'b0, 4'd0,  1'b0, 1'b0, 32'h000B_FFFF, 1'b0, 3'b000}, // R2 below window
        {1'b0, 4'd0,  1'b0, 1'b0, 32'h0010_0000, 1'b0, 3'b000}, // R2 above window
        {1'b0, 4'd0,  1'b0, 1'b0, 32'h001F_C000, 1'b1, 3'b000}, // R7 alias not matched
        {1'b0, 4'd0,  1'b0, 1'b0, 32'h000C_4000, 1'b1, 3'b010}  // R7 seg1 untouched
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_seg = '0;
    logic        cfg_rd_dram = 1'b0;
    logic        cfg_wr_dram = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        dram_sel, fwd_sel, wr_drop;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    shadow_router u_shadow_router (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_seg(cfg_seg),
        .cfg_rd_dram(cfg_rd_dram), .cfg_wr_dram(cfg_wr_dram),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .dram_sel(dram_sel), .fwd_sel(fwd_sel), .wr_drop(wr_drop)
    );

    task automatic check(input string req, input logic [2:0] exp);
        logic [2:0] got;
        got = {dram_sel, fwd_sel, wr_drop};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: {dram,fwd,drop} got %b expected %b", req, got, exp);
        end
    endtask

    task automatic idle();
        cfg_we = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 3'b000);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            cfg_we      = v[42];
            cfg_seg     = v[41:38];
            cfg_rd_dram = v[37];
            cfg_wr_dram = v[36];
            acc_addr    = v[35:4];
            acc_write   = v[3];
            acc_valid   = !v[42];
            @(negedge clk);
            idle();
            check($sformatf("R2/R3/R4 vector %0d", i), v[2:0]);
        end

        // R2: idle cycle produces no strobe
        @(negedge clk);
        check("R2 idle", 3'b000);

        // R8: config and access in the same cycle use the old attributes
        cfg_we = 1'b1; cfg_seg = 4'd1; cfg_rd_dram = 1'b1; cfg_wr_dram = 1'b1;
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 32'h000C_4000;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R8 same cycle old attr", 3'b010);
        @(negedge clk);
        idle();
        check("R8 next cycle new attr", 3'b100);

        // R1: reset mid-run clears attributes and outputs
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 32'h000C_0000;
        @(negedge clk);
        idle();
        check("R3 before reset", 3'b100);
        rst_n = 1'b0;
        #1;
        check("R1 in reset", 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        acc_valid = 1'b1; acc_addr = 32'h000C_0000;
        @(negedge clk);
        idle();
        check("R1 attrs cleared", 3'b010);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule